// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block builds the interrupt outputs of a serial port from two kinds of input: the current fill counts of the receive and transmit FIFOs, and one-cycle strobes that report a receive timeout, a framing error, a parity error, a line break and an overrun. It keeps an 11-bit raw status word, a mask, and a masked view of the status. A write-one-to-clear port removes latched events. One registered interrupt line is the OR of every masked status bit.

The two FIFO level bits are programmed on their own. Each takes a 3-bit code that picks a fraction of the FIFO depth. The receive bit fires when the FIFO is at least that full. The transmit bit fires when the FIFO has drained to that fill or below. Both level bits track the fill counts as they change. The five event bits stay set until software clears them.

A small register port gives software access. It takes a write strobe, a 3-bit address and write data, and returns combinational read data. The addresses are: 0 level select, 1 mask, 2 raw status, 3 masked status, 4 clear. The clear address is write-only and reads back as zero, as do addresses 5 to 7.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the level-select register reads 0x12 (both codes 2), the mask reads 0, all five event bits read 0, and `irq_out` is low.
- R2: Level select at address 0 holds the transmit code in bits 2:0 and the receive code in bits 5:3. It changes only on a write to address 0, and it reads back exactly as written.
- R3: Threshold codes 0, 1, 2, 3 and 4 select floor(DEPTH×k/8), where k is 1, 2, 4, 6 and 7 in that order. With DEPTH 16 this gives 2, 4, 8, 12 and 14.
- R4: Raw status bit 4 is 1 exactly when `rx_fill` is greater than or equal to the receive threshold.
- R5: Raw status bit 5 is 1 exactly when `tx_fill` is less than or equal to the transmit threshold.
- R6: Codes 5, 6 and 7 behave as code 2 (half of DEPTH) for both directions.
- R7: One-cycle strobes set sticky raw bits one cycle later. The bits are: timeout 6, framing 7, parity 8, break 9, overrun 10. A set bit stays set until it is cleared.
- R8: Writing address 4 clears each event bit whose write-data bit is 1. Bits written 0 are unchanged. Writes to bits 4 and 5 have no effect. Address 4 reads 0.
- R9: When a strobe and a clear hit the same event bit in the same cycle, the bit ends up set.
- R10: The mask at address 1 stores only bits 10:4; the others read 0. Address 3 reads raw status AND mask.
- R11: `irq_out` equals the OR of the masked status bits of the previous cycle.
- R12: A level bit drops without any clear once its fill condition no longer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_fill | input | FILL_W | Receive FIFO fill count, 0..DEPTH |
| tx_fill | input | FILL_W | Transmit FIFO fill count, 0..DEPTH |
| ev_rx_timeout | input | 1 | Receive timeout strobe |
| ev_frame_err | input | 1 | Framing error strobe |
| ev_parity_err | input | 1 | Parity error strobe |
| ev_break | input | 1 | Break strobe |
| ev_overrun | input | 1 | Overrun strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational register read data |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
The properties assume that fill counts never go above DEPTH. This matters because a full receive FIFO must always meet any receive threshold, and an empty transmit FIFO must always meet any transmit threshold. Event strobes are taken as one-cycle pulses that can coincide with clear writes. The stimulus draws fills only in 0..DEPTH. It also drops each strobe for at least one cycle after raising it, and it deliberately overlaps strobes with clears of the same bit.

// File: rtl/uic_pkg.sv
package uic_pkg;
   localparam int ST_W    = 11;
   localparam int BIT_RXL = 4;
   localparam int BIT_TXL = 5;
   localparam int EV_LO   = 6;
   localparam int EV_N    = 5;
   localparam int EV_HI   = EV_LO + EV_N - 1;

   typedef enum logic [2:0] {
      A_LEVEL  = 3'd0,
      A_MASK   = 3'd1,
      A_RAW    = 3'd2,
      A_MASKED = 3'd3,
      A_CLEAR  = 3'd4
   } reg_addr_e;

   localparam logic [5:0] LEVEL_RST = 6'b010_010;

   // numerator (in eighths of depth) selected by a threshold code
   function automatic int unsigned eighths(input logic [2:0] code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 6;
         3'd4:    return 7;
         default: return 4;   // reserved codes fall back to one half
      endcase
   endfunction
endpackage

// File: rtl/uic_level_cmp.sv
module uic_level_cmp
   import uic_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int FILL_W   = 5,
   parameter bit AT_LEAST = 1'b1
) (
   input  logic [2:0]        code,
   input  logic [FILL_W-1:0] fill,
   output logic              hit
);
   logic [FILL_W-1:0] thr_tbl [8];
   logic [FILL_W-1:0] thr;

   for (genvar c = 0; c < 8; c++) begin : g_thr
      localparam int unsigned T = (DEPTH * eighths(3'(c))) / 8;
      assign thr_tbl[c] = FILL_W'(T);
   end

   assign thr = thr_tbl[code];

   if (AT_LEAST) begin : g_ge
      assign hit = (fill >= thr);
   end else begin : g_le
      assign hit = (fill <= thr);
   end
endmodule

// File: rtl/uic_sticky_bank.sv
module uic_sticky_bank #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (set[i]) q[i] <= 1'b1;   // set dominates a same-cycle clear
         else if (clr[i]) q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/uic_regs.sv
module uic_regs
   import uic_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ST_W-1:0]   raw,
   output logic [5:0]        lvl_q,
   output logic [ST_W-1:0]   mask_q,
   output logic [ST_W-1:0]   masked,
   output logic [EV_N-1:0]   clr_ev,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ST_W-1:0] MASK_KEEP = {{(ST_W-BIT_RXL){1'b1}}, {BIT_RXL{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= LEVEL_RST;
         mask_q <= '0;
      end else if (wr) begin
         if (addr == A_LEVEL) lvl_q  <= wdata[5:0];
         if (addr == A_MASK)  mask_q <= wdata[ST_W-1:0] & MASK_KEEP;
      end
   end

   assign masked = raw & mask_q;
   assign clr_ev = (wr && addr == A_CLEAR) ? wdata[EV_HI:EV_LO] : '0;

   always_comb begin
      rdata = '0;
      case (addr)
         A_LEVEL:  rdata[5:0]      = lvl_q;
         A_MASK:   rdata[ST_W-1:0] = mask_q;
         A_RAW:    rdata[ST_W-1:0] = raw;
         A_MASKED: rdata[ST_W-1:0] = masked;
         default:  rdata = '0;
      endcase
   end

   if (DATA_W > ST_W) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:ST_W];
   end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uic_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 16,
   localparam int FILL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FILL_W-1:0] rx_fill,
   input  logic [FILL_W-1:0] tx_fill,
   input  logic              ev_rx_timeout,
   input  logic              ev_frame_err,
   input  logic              ev_parity_err,
   input  logic              ev_break,
   input  logic              ev_overrun,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out
);
   if (DEPTH < 8) begin : g_bad_depth
      $error("uart_irq_ctrl: DEPTH must be at least 8");
   end
   if (DATA_W < ST_W) begin : g_bad_width
      $error("uart_irq_ctrl: DATA_W must hold the status word");
   end

   logic            rx_hit, tx_hit;
   logic [5:0]      lvl_q;
   logic [ST_W-1:0] mask_q, masked_vec, raw_vec;
   logic [EV_N-1:0] ev_vec, clr_ev, sticky;
   logic            irq_q;

   uic_level_cmp #(.DEPTH(DEPTH), .FILL_W(FILL_W), .AT_LEAST(1'b1)) rx_cmp_i (
      .code(lvl_q[5:3]), .fill(rx_fill), .hit(rx_hit));

   uic_level_cmp #(.DEPTH(DEPTH), .FILL_W(FILL_W), .AT_LEAST(1'b0)) tx_cmp_i (
      .code(lvl_q[2:0]), .fill(tx_fill), .hit(tx_hit));

   assign ev_vec = {ev_overrun, ev_break, ev_parity_err, ev_frame_err, ev_rx_timeout};

   uic_sticky_bank #(.N(EV_N)) sticky_i (
      .clk(clk), .rst_n(rst_n), .set(ev_vec), .clr(clr_ev), .q(sticky));

   assign raw_vec = {sticky, tx_hit, rx_hit, {BIT_RXL{1'b0}}};

   uic_regs #(.DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .raw(raw_vec), .lvl_q(lvl_q), .mask_q(mask_q), .masked(masked_vec),
      .clr_ev(clr_ev), .rdata(reg_rdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |masked_vec;
   end

   assign irq_out = irq_q;
endmodule

// File: rtl/uic_checker.sv
module uic_checker #(
   parameter int DEPTH  = 16,
   parameter int FILL_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FILL_W-1:0] rx_fill,
   input logic [FILL_W-1:0] tx_fill,
   input logic              ev_overrun,
   input logic              ev_break,
   input logic              ev_parity_err,
   input logic              clr_wr,
   input logic              lvl_wr,
   input logic [4:0]        clr_bits,
   input logic [10:0]       raw_vec,
   input logic [10:0]       mask_q,
   input logic [5:0]        lvl_q,
   input logic              irq_out
);
   a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_overrun |=> raw_vec[10]);

   a_r7_frame_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_vec[7] && !(clr_wr && clr_bits[1])) |=> raw_vec[7]);

   a_r8_parity_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_bits[2] && !ev_parity_err) |=> !raw_vec[8]);

   a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_bits[3] && ev_break) |=> raw_vec[9]);

   a_r4_full_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rx_fill) >= DEPTH) |-> raw_vec[4]);

   a_r5_empty_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_fill == '0) |-> raw_vec[5]);

   a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (|(raw_vec & mask_q)) |=> irq_out);

   a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(raw_vec & mask_q)) |=> !irq_out);

   a_r2_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_wr |=> $stable(lvl_q));
endmodule

bind uart_irq_ctrl uic_checker #(.DEPTH(DEPTH), .FILL_W(FILL_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .tx_fill(tx_fill),
   .ev_overrun(ev_overrun), .ev_break(ev_break), .ev_parity_err(ev_parity_err),
   .clr_wr(reg_wr && reg_addr == 3'd4), .lvl_wr(reg_wr && reg_addr == 3'd0),
   .clr_bits(reg_wdata[10:6]), .raw_vec(raw_vec), .mask_q(mask_q),
   .lvl_q(lvl_q), .irq_out(irq_out));

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
   localparam int DEPTH = 16;
   localparam int FW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [FW-1:0] rx_fill = '0, tx_fill = '0;
   logic [4:0]    ev = '0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          irq_out;

   int    n_cmp = 0, n_bad = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   uart_irq_ctrl #(.DEPTH(DEPTH), .DATA_W(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .tx_fill(tx_fill),
      .ev_rx_timeout(ev[0]), .ev_frame_err(ev[1]), .ev_parity_err(ev[2]),
      .ev_break(ev[3]), .ev_overrun(ev[4]),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_out(irq_out));

   // ---------------- reference model ----------------
   logic [5:0]  m_lvl;
   logic [10:0] m_mask;
   logic [4:0]  m_stk;
   logic        m_irq;

   function automatic int thr(input logic [2:0] code);
      int k;
      case (code)
         3'd0: k = 1;  3'd1: k = 2;  3'd2: k = 4;
         3'd3: k = 6;  3'd4: k = 7;  default: k = 4;
      endcase
      return (DEPTH * k) / 8;
   endfunction

   function automatic logic [10:0] m_raw();
      logic rxl, txl;
      rxl = (int'(rx_fill) >= thr(m_lvl[5:3]));
      txl = (int'(tx_fill) <= thr(m_lvl[2:0]));
      return {m_stk, txl, rxl, 4'b0000};
   endfunction

   function automatic logic [15:0] m_read(input logic [2:0] a);
      case (a)
         3'd0:    return {10'b0, m_lvl};
         3'd1:    return {5'b0, m_mask};
         3'd2:    return {5'b0, m_raw()};
         3'd3:    return {5'b0, m_raw() & m_mask};
         default: return 16'h0000;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lvl = 6'h12; m_mask = '0; m_stk = '0; m_irq = 1'b0;
      end else begin
         logic [10:0] r;
         r = m_raw();
         m_irq = |(r & m_mask);
         if (reg_wr && reg_addr == 3'd4) m_stk = m_stk & ~reg_wdata[10:6];
         m_stk = m_stk | ev;
         if (reg_wr && reg_addr == 3'd0) m_lvl = reg_wdata[5:0];
         if (reg_wr && reg_addr == 3'd1) m_mask = reg_wdata[10:0] & 11'h7F0;
      end
   end

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R11", {15'b0, irq_out}, {15'b0, m_irq});
         check(cur_req, reg_rdata, m_read(reg_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(negedge clk); #2;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic pulse(input logic [4:0] v);
      ev = v; step(); ev = '0;
   endtask

   task automatic peek(input string req, input logic [2:0] a, input logic [15:0] exp);
      reg_addr = a; #3;
      check(req, reg_rdata, exp);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state (tx_fill 0 makes bit 5 high)
      check("R1", {15'b0, irq_out}, 16'h0000);
      peek("R1", 3'd0, 16'h0012);
      peek("R1", 3'd1, 16'h0000);
      peek("R1", 3'd2, 16'h0020);
      tx_fill = 5'd12;
      step();

      // R2 layout of level select
      cur_req = "R2";
      wr(3'd0, 16'h001A);
      peek("R2", 3'd0, 16'h001A);
      step();

      // R3 code 0 threshold is 2 for depth 16
      cur_req = "R3";
      wr(3'd0, 16'h0000);
      rx_fill = 5'd1; step(); peek("R3", 3'd2, 16'h0000);
      rx_fill = 5'd2; step(); peek("R3", 3'd2, 16'h0010);
      tx_fill = 5'd2; step(); peek("R3", 3'd2, 16'h0030);
      tx_fill = 5'd3; step(); peek("R3", 3'd2, 16'h0010);

      // R4 receive sweep, R5 transmit sweep
      reg_addr = 3'd2;
      for (int c = 0; c < 5; c++) begin
         cur_req = "R4";
         wr(3'd0, 16'((c << 3) | 2));
         reg_addr = 3'd2;
         for (int f = 0; f <= DEPTH; f++) begin rx_fill = FW'(f); step(); end
         cur_req = "R5";
         wr(3'd0, 16'((2 << 3) | c));
         reg_addr = 3'd2;
         for (int f = 0; f <= DEPTH; f++) begin tx_fill = FW'(f); step(); end
      end

      // R6 reserved codes act as half depth
      cur_req = "R6";
      for (int c = 5; c < 8; c++) begin
         wr(3'd0, 16'((c << 3) | c));
         rx_fill = 5'd8; tx_fill = 5'd8; step(); peek("R6", 3'd2, 16'h0030);
         rx_fill = 5'd7; tx_fill = 5'd9; step(); peek("R6", 3'd2, 16'h0000);
      end

      // R7 sticky events at bits 6..10
      cur_req = "R7";
      rx_fill = 5'd0; tx_fill = 5'd9;
      wr(3'd0, 16'h0012);
      for (int i = 0; i < 5; i++) pulse(5'(1 << i));
      peek("R7", 3'd2, 16'h07C0);
      repeat (4) step();
      peek("R7", 3'd2, 16'h07C0);

      // R8 clear bits 6,7 plus level bits 4,5 while both levels active
      cur_req = "R8";
      rx_fill = 5'd10; tx_fill = 5'd1; step();
      wr(3'd4, 16'h00F0);
      peek("R8", 3'd2, 16'h0730);
      peek("R8", 3'd4, 16'h0000);

      // R9 strobe and clear on overrun together
      cur_req = "R9";
      reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0400; ev = 5'b10000;
      step();
      reg_wr = 1'b0; ev = '0;
      peek("R9", 3'd2, 16'h0730);

      // R12 level bits fall without a clear
      cur_req = "R12";
      rx_fill = 5'd3; tx_fill = 5'd15; step();
      peek("R12", 3'd2, 16'h0700);

      // R10 mask storage and masked view
      cur_req = "R10";
      wr(3'd1, 16'hFFFF);
      peek("R10", 3'd1, 16'h07F0);
      wr(3'd1, 16'h0080);
      peek("R10", 3'd3, 16'h0000);

      // R11 interrupt follows mask one cycle later
      cur_req = "R11";
      wr(3'd4, 16'h07C0);
      check("R11", {15'b0, irq_out}, 16'h0000);
      wr(3'd1, 16'h0200);
      pulse(5'b01000);
      check("R11", {15'b0, irq_out}, 16'h0000);
      step();
      check("R11", {15'b0, irq_out}, 16'h0001);
      peek("R10", 3'd3, 16'h0200);

      // mixed traffic against the model
      cur_req = "R10";
      for (int n = 0; n < 3000; n++) begin
         logic [4:0] nev;
         rx_fill = FW'($urandom_range(0, DEPTH));
         tx_fill = FW'($urandom_range(0, DEPTH));
         nev = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'b0;
         ev = (ev != 0) ? 5'b0 : nev;
         reg_addr = 3'($urandom_range(0, 7));
         reg_wr = ($urandom_range(0, 4) == 0);
         reg_wdata = 16'($urandom);
         if (reg_wr && reg_addr == 3'd0) reg_wdata[5:0] = 6'($urandom_range(0, 63));
         step();
      end
      reg_wr = 1'b0; ev = '0;
      step(); step();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule